// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns single internal read and write requests into cycles on an external memory bus. On acceptance of a request it compares the address with a small set of programmable address windows. The matching window supplies the whole shape of the cycle: multiplexed or separate address port, 8-bit or 16-bit data, address-latch pulse length, strobe delay, wait states, ready handshake, write release point, recovery time and chip-select behaviour. If no window matches, a default configuration applies. This lets back-to-back cycles to different devices use different protocols.

The pins are modelled as separate signals: an address port, a data-out port with its enable, a data-in port, an address-latch strobe, a read strobe, two byte write strobes, a ready input, one chip select per window and up to seven upper segment address lines. Pad drivers and bus arbitration are outside the block.

On a 16-bit bus a byte write copies the byte to both halves and pulses only the write strobe of the addressed half. On an 8-bit bus a word access becomes two full bus cycles, low byte first.

Top module: `extbus_ctrl`

## Requirements
- R1: A request uses the lowest-numbered enabled window for which `((addr ^ base) >> size) == 0`. If no window matches, it uses `dflt_cfg` and drives no chip select. Each configuration word is laid out as {csmode[1:0], bus16, mux, ale_long, rw_dly, early_wr, tri_none, rdy_en, waits[3:0]}, MSB first.
- R2: With `mux`=1 the address goes out on `bus_dout` with `bus_doe`=1 during the latch and hold cycles, and `bus_addr` stays 0. With `mux`=0 `bus_addr` carries the current address in every active cycle, and the data port is not driven in the address cycles.
- R3: `bus_ale` is high for one cycle. With `ale_long`=1 it is high for two cycles and is followed by one hold cycle in which the address is still driven.
- R4: With `rw_dly`=1 one cycle with no strobe and no data drive comes before the strobe.
- R5: The read or write strobe phase lasts `waits`+1 cycles when the ready handshake is off.
- R6: With `rdy_en`=1 `bus_rdy` is ignored during the first `waits` strobe cycles. After that the strobe continues until `bus_rdy` is sampled high. With `rdy_en`=0 `bus_rdy` has no effect.
- R7: Each cycle ends with one data-hold cycle. With `tri_none`=0 an extra idle recovery cycle follows it; with `tri_none`=1 it does not.
- R8: A normal write (`early_wr`=0) keeps its write strobe active through the data-hold cycle. An early write drops the strobe at the end of the strobe phase, while the data stay driven through the hold cycle.
- R9: On a 16-bit bus a word write asserts both `bus_wrl` and `bus_wrh`. A byte write drives `req_wdata[7:0]` on both data halves and asserts only `bus_wrl` (even address) or only `bus_wrh` (odd address).
- R10: On an 8-bit bus a word access runs two complete cycles, at addr and addr+1. The low byte comes first, and only `bus_wrl` is used as the write strobe.
- R11: `seg_sel` sets how many address bits from bit 16 upward appear on `bus_seg`: 00 gives four lines, 01 none, 10 seven and 11 two. Unused lines and inactive cycles give 0.
- R12: `csmode` 00 gives an address chip select. It rises with the first cycle to its window and stays high until a request goes to another window or to the default configuration. `csmode` 01 follows the read strobe, 10 follows the write strobes, and 11 follows both.
- R13: After reset all strobes, chip selects, `bus_doe`, `bus_addr`, `bus_seg` and `rsp_done` are 0, and `req_ready` is 1.
- R14: `rsp_done` pulses for one cycle in the first idle cycle after a request. With it, `rsp_rdata` holds the read data sampled on the last strobe cycle: a full word, or a byte zero-extended (an odd byte on a 16-bit bus comes from `bus_din[15:8]`), or on an 8-bit bus the two beats assembled low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_base | input | NWIN*AW | Base address per window |
| win_size | input | NWIN*SIZE_W | Count of ignored low address bits per window |
| win_en | input | NWIN | Window enables |
| win_cfg | input | NWIN*CFG_W | Cycle configuration per window |
| dflt_cfg | input | CFG_W | Configuration used when no window matches |
| seg_sel | input | 2 | Segment line count code |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_addr | input | AW | Request byte address |
| req_we | input | 1 | 1 = write |
| req_byte | input | 1 | 1 = byte access |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| rsp_done | output | 1 | Request finished pulse |
| rsp_rdata | output | 16 | Read result |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wrl | output | 1 | Low byte write strobe |
| bus_wrh | output | 1 | High byte write strobe |
| bus_addr | output | 16 | Separate address port |
| bus_seg | output | 7 | Segment address lines |
| bus_dout | output | 16 | Address/data out |
| bus_doe | output | 1 | Data port drive enable |
| bus_din | input | 16 | Data in |
| bus_rdy | input | 1 | Ready, active high |
| bus_cs | output | NWIN | Chip selects |

## Verification
The assertions check on every cycle that no strobe overlaps the latch strobe, that the data port is never driven while reading or during the delay cycle, that at most one chip select is high, and that the segment port stays quiet when no lines are selected. They also check that the strobe phase cannot end before its wait count and that the done pulse only appears when idle. The exact per-cycle shape of each configuration can only be shown by the bench's scenarios: latch length, hold and recovery cycles, the cycles added by ready, the early write release, byte lane placement, the two-beat split, and chip select release on a change of window.

// File: rtl/extbus_pkg.sv
// Shared types for the external bus cycle controller.
// Assumes a 16-bit external data port and a 16-bit low address port.
package extbus_pkg;
    localparam int WAIT_W  = 4;
    localparam int DATA_W  = 16;
    localparam int LOW_AW  = 16;
    localparam int SEG_MAX = 7;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ALE, PH_HOLD, PH_DLY, PH_STB, PH_END, PH_TRI
    } phase_t;

    typedef struct packed {
        logic [1:0]        csmode;
        logic              bus16;
        logic              mux;
        logic              ale_long;
        logic              rw_dly;
        logic              early_wr;
        logic              tri_none;
        logic              rdy_en;
        logic [WAIT_W-1:0] waits;
    } wcfg_t;

    localparam int CFG_W = $bits(wcfg_t);

    // Number of segment lines for a select code.
    function automatic int seg_lines(input logic [1:0] sel);
        case (sel)
            2'b00:   return 4;
            2'b01:   return 0;
            2'b10:   return 7;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/extbus_win_match.sv
// Window matcher: picks the lowest-numbered enabled window whose
// significant upper address bits equal its base; otherwise the default.
// Assumes size values at or above AW make a window match everything.
module extbus_win_match
    import extbus_pkg::*;
#(
    parameter int NWIN   = 4,
    parameter int AW     = 24,
    parameter int SIZE_W = 5,
    parameter int IDX_W  = 2
) (
    input  logic [AW-1:0]          addr,
    input  logic [NWIN*AW-1:0]     base,
    input  logic [NWIN*SIZE_W-1:0] size,
    input  logic [NWIN-1:0]        en,
    input  logic [NWIN*CFG_W-1:0]  cfgs,
    input  logic [CFG_W-1:0]       dflt,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx,
    output wcfg_t                  cfg
);
    logic [NWIN-1:0] match;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [AW-1:0] diff;
        assign diff     = addr ^ base[w*AW +: AW];
        assign match[w] = en[w] && ((diff >> size[w*SIZE_W +: SIZE_W]) == '0);
    end

    // Priority select: the lowest index is assigned last and wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        cfg = wcfg_t'(dflt);
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit = 1'b1;
                idx = IDX_W'(w);
                cfg = wcfg_t'(cfgs[w*CFG_W +: CFG_W]);
            end
        end
    end
endmodule

// File: rtl/extbus_seq.sv
// Cycle sequencer: walks latch, hold, delay, strobe, data-hold and
// recovery phases for each bus cycle and splits word accesses on an
// 8-bit bus into two beats. Assumes word addresses are even.
module extbus_seq
    import extbus_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  wcfg_t             cfg_in,
    input  logic [AW-1:0]     addr_in,
    input  logic              we_in,
    input  logic              byte_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              bus_rdy,
    output phase_t            phase,
    output wcfg_t             cfg_q,
    output logic [AW-1:0]     addr_q,
    output logic              we_q,
    output logic              byte_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              beat_q,
    output logic              capture,
    output logic              done_q
);
    logic [WAIT_W-1:0] cnt;
    logic              more_beat;
    phase_t            after_ale;
    phase_t            after_hold;

    // Strobe phase ends once waits are spent and ready allows it.
    always_comb begin
        capture    = (phase == PH_STB) && (cnt == cfg_q.waits) &&
                     (!cfg_q.rdy_en || bus_rdy);
        more_beat  = !cfg_q.bus16 && !byte_q && !beat_q;
        after_hold = cfg_q.rw_dly ? PH_DLY : PH_STB;
        after_ale  = cfg_q.ale_long ? PH_HOLD : after_hold;
    end

    // Phase register, wait counter and request latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            cfg_q   <= '0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            byte_q  <= 1'b0;
            wdata_q <= '0;
            beat_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        addr_q  <= addr_in;
                        we_q    <= we_in;
                        byte_q  <= byte_in;
                        wdata_q <= wdata_in;
                        beat_q  <= 1'b0;
                        cnt     <= '0;
                        phase   <= PH_ALE;
                    end
                end
                PH_ALE: begin
                    if (cfg_q.ale_long && cnt == '0) begin
                        cnt <= WAIT_W'(1);
                    end else begin
                        cnt   <= '0;
                        phase <= after_ale;
                    end
                end
                PH_HOLD: phase <= after_hold;
                PH_DLY:  phase <= PH_STB;
                PH_STB: begin
                    if (cnt != cfg_q.waits) begin
                        cnt <= cnt + WAIT_W'(1);
                    end else if (capture) begin
                        cnt   <= '0;
                        phase <= PH_END;
                    end
                end
                PH_END, PH_TRI: begin
                    if (phase == PH_END && !cfg_q.tri_none) begin
                        phase <= PH_TRI;
                    end else if (more_beat) begin
                        beat_q <= 1'b1;
                        addr_q <= addr_q + AW'(1);
                        phase  <= PH_ALE;
                    end else begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STB && cnt != cfg_q.waits) |=> (phase == PH_STB)); // R6
    AST_ALE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ALE && !cfg_q.ale_long) |=> (phase != PH_ALE)); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (phase == PH_IDLE)); // R14
endmodule

// File: rtl/extbus_pins.sv
// Pin driver: decodes the sequencer phase into strobes, address, data
// lanes, segment lines and chip selects, and assembles read data.
// Assumes byte write data sit in the low byte of the request.
module extbus_pins
    import extbus_pkg::*;
#(
    parameter int NWIN  = 4,
    parameter int AW    = 24,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hit_in,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [1:0]        csmode_in,
    input  phase_t            phase,
    input  wcfg_t             cfg_q,
    input  logic [AW-1:0]     addr_q,
    input  logic              we_q,
    input  logic              byte_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              beat_q,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [1:0]        seg_sel,
    output logic              bus_ale,
    output logic              bus_rd,
    output logic              bus_wrl,
    output logic              bus_wrh,
    output logic [LOW_AW-1:0] bus_addr,
    output logic [SEG_MAX-1:0] bus_seg,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic [NWIN-1:0]   bus_cs,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic              active;
    logic              addr_ph;
    logic              wr_act;
    logic [7:0]        beat_byte;
    logic [DATA_W-1:0] wr_lanes;
    logic [NWIN-1:0]   cs_hold;
    logic              hit_q;
    logic [IDX_W-1:0]  idx_q;
    int                nseg;

    // Strobes and data lanes decoded from the current phase.
    always_comb begin
        active    = (phase != PH_IDLE) && (phase != PH_TRI);
        addr_ph   = (phase == PH_ALE) || (phase == PH_HOLD);
        bus_ale   = (phase == PH_ALE);
        bus_rd    = (phase == PH_STB) && !we_q;
        wr_act    = we_q && ((phase == PH_STB) ||
                             (phase == PH_END && !cfg_q.early_wr));
        bus_wrl   = wr_act && (!cfg_q.bus16 || !byte_q || !addr_q[0]);
        bus_wrh   = wr_act && cfg_q.bus16 && (!byte_q || addr_q[0]);
        beat_byte = beat_q ? wdata_q[15:8] : wdata_q[7:0];
        if (!cfg_q.bus16)  wr_lanes = {8'h00, beat_byte};
        else if (byte_q)   wr_lanes = {wdata_q[7:0], wdata_q[7:0]};
        else               wr_lanes = wdata_q;
        bus_addr  = (active && !cfg_q.mux) ? addr_q[LOW_AW-1:0] : '0;
        if (cfg_q.mux && addr_ph) begin
            bus_doe  = 1'b1;
            bus_dout = addr_q[LOW_AW-1:0];
        end else if (we_q && (phase == PH_STB || phase == PH_END)) begin
            bus_doe  = 1'b1;
            bus_dout = wr_lanes;
        end else begin
            bus_doe  = 1'b0;
            bus_dout = '0;
        end
        nseg = seg_lines(seg_sel);
    end

    for (genvar i = 0; i < SEG_MAX; i++) begin : g_seg
        if (LOW_AW + i < AW) begin : g_on
            assign bus_seg[i] = active && (i < nseg) && addr_q[LOW_AW+i];
        end else begin : g_off
            assign bus_seg[i] = 1'b0;
        end
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_cs
        logic mine;
        assign mine      = hit_q && (idx_q == IDX_W'(w));
        assign bus_cs[w] = cs_hold[w] ||
                           (mine && ((cfg_q.csmode[0] && bus_rd) ||
                                     (cfg_q.csmode[1] && (bus_wrl || bus_wrh))));
    end

    // Window latch and address chip select hold, updated per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_hold <= '0;
            hit_q   <= 1'b0;
            idx_q   <= '0;
        end else if (start) begin
            hit_q <= hit_in;
            idx_q <= idx_in;
            for (int w = 0; w < NWIN; w++) begin
                cs_hold[w] <= hit_in && (idx_in == IDX_W'(w)) && (csmode_in == 2'b00);
            end
        end
    end

    // Read data assembly on the last strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (start) begin
            rsp_rdata <= '0;
        end else if (capture && !we_q) begin
            if (cfg_q.bus16 && !byte_q)      rsp_rdata <= bus_din;
            else if (cfg_q.bus16)            rsp_rdata <= {8'h00, addr_q[0] ? bus_din[15:8] : bus_din[7:0]};
            else if (byte_q)                 rsp_rdata <= {8'h00, bus_din[7:0]};
            else if (beat_q)                 rsp_rdata[15:8] <= bus_din[7:0];
            else                             rsp_rdata[7:0]  <= bus_din[7:0];
        end
    end

    AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (!bus_rd && !bus_wrl && !bus_wrh)); // R3
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !bus_doe); // R2
    AST_DLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DLY) |-> (!bus_doe && !bus_rd && !bus_wrl && !bus_wrh)); // R4
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_cs)); // R12
    AST_SEG_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_sel == 2'b01) |-> (bus_seg == '0)); // R11
endmodule

// File: rtl/extbus_ctrl.sv
// Top of the external bus cycle controller: window matcher, cycle
// sequencer and pin driver. Assumes configuration inputs only change
// while the controller is idle.
module extbus_ctrl
    import extbus_pkg::*;
#(
    parameter int NWIN   = 4,
    parameter int AW     = 24,
    parameter int SIZE_W = 5,
    localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NWIN*AW-1:0]     win_base,
    input  logic [NWIN*SIZE_W-1:0] win_size,
    input  logic [NWIN-1:0]        win_en,
    input  logic [NWIN*CFG_W-1:0]  win_cfg,
    input  logic [CFG_W-1:0]       dflt_cfg,
    input  logic [1:0]             seg_sel,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [AW-1:0]          req_addr,
    input  logic                   req_we,
    input  logic                   req_byte,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_done,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   bus_ale,
    output logic                   bus_rd,
    output logic                   bus_wrl,
    output logic                   bus_wrh,
    output logic [LOW_AW-1:0]      bus_addr,
    output logic [SEG_MAX-1:0]     bus_seg,
    output logic [DATA_W-1:0]      bus_dout,
    output logic                   bus_doe,
    input  logic [DATA_W-1:0]      bus_din,
    input  logic                   bus_rdy,
    output logic [NWIN-1:0]        bus_cs
);
    logic              hit;
    logic [IDX_W-1:0]  idx;
    wcfg_t             sel_cfg;
    logic              start;
    phase_t            phase;
    wcfg_t             cfg_q;
    logic [AW-1:0]     addr_q;
    logic              we_q;
    logic              byte_q;
    logic [DATA_W-1:0] wdata_q;
    logic              beat_q;
    logic              capture;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    extbus_win_match #(.NWIN(NWIN), .AW(AW), .SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_match (
        .addr(req_addr), .base(win_base), .size(win_size), .en(win_en),
        .cfgs(win_cfg), .dflt(dflt_cfg), .hit(hit), .idx(idx), .cfg(sel_cfg)
    );

    extbus_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(sel_cfg),
        .addr_in(req_addr), .we_in(req_we), .byte_in(req_byte),
        .wdata_in(req_wdata), .bus_rdy(bus_rdy), .phase(phase),
        .cfg_q(cfg_q), .addr_q(addr_q), .we_q(we_q), .byte_q(byte_q),
        .wdata_q(wdata_q), .beat_q(beat_q), .capture(capture), .done_q(rsp_done)
    );

    extbus_pins #(.NWIN(NWIN), .AW(AW), .IDX_W(IDX_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .start(start), .hit_in(hit), .idx_in(idx),
        .csmode_in(sel_cfg.csmode), .phase(phase), .cfg_q(cfg_q),
        .addr_q(addr_q), .we_q(we_q), .byte_q(byte_q), .wdata_q(wdata_q),
        .beat_q(beat_q), .capture(capture), .bus_din(bus_din),
        .seg_sel(seg_sel), .bus_ale(bus_ale), .bus_rd(bus_rd),
        .bus_wrl(bus_wrl), .bus_wrh(bus_wrh), .bus_addr(bus_addr),
        .bus_seg(bus_seg), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_cs(bus_cs), .rsp_rdata(rsp_rdata)
    );

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready); // R14
endmodule

// File: tb/sim_extbus_ctrl.sv
module sim_extbus_ctrl;
    localparam int NWIN = 4, AW = 24, SIZE_W = 5, CFG_W = 13;

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic [NWIN*AW-1:0]     win_base;
    logic [NWIN*SIZE_W-1:0] win_size;
    logic [NWIN-1:0]        win_en;
    logic [NWIN*CFG_W-1:0]  win_cfg;
    logic [CFG_W-1:0]       dflt_cfg;
    logic [1:0]  seg_sel = 2'b01;
    logic        req_valid = 0, req_we = 0, req_byte = 0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0, bus_din = '0;
    logic        bus_rdy = 0;
    logic        req_ready, rsp_done, bus_ale, bus_rd, bus_wrl, bus_wrh, bus_doe;
    logic [15:0] rsp_rdata, bus_addr, bus_dout;
    logic [6:0]  bus_seg;
    logic [3:0]  bus_cs;

    extbus_ctrl u0 (.*);

    typedef struct {
        bit ale, rd, wrl, wrh, doe, rdy;
        bit [15:0] dout, addr, din;
        bit [6:0] seg;
        bit [3:0] cs;
    } cyc_t;

    int errors = 0, checks = 0;
    bit finished = 0;
    // Bench view of the configuration: index 4 is the default.
    int c_wait[5], c_rdy[5], c_trin[5], c_early[5], c_dly[5], c_along[5], c_mux[5], c_b16[5], c_csm[5];
    int w_base[4], w_size[4], w_en[4];
    bit [3:0] cs_hold_m = 0;

    task automatic chk(string tag, string ctx, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%h expected=%h", tag, ctx, act, exp);
        end
    endtask

    task automatic set_cfg(int i, int wt, int rdy, int trin, int early, int dly, int along, int mux, int b16, int csm);
        c_wait[i] = wt; c_rdy[i] = rdy; c_trin[i] = trin; c_early[i] = early; c_dly[i] = dly;
        c_along[i] = along; c_mux[i] = mux; c_b16[i] = b16; c_csm[i] = csm;
    endtask

    function automatic logic [CFG_W-1:0] pack(int i);
        return {2'(c_csm[i]), 1'(c_b16[i]), 1'(c_mux[i]), 1'(c_along[i]), 1'(c_dly[i]),
                1'(c_early[i]), 1'(c_trin[i]), 1'(c_rdy[i]), 4'(c_wait[i])};
    endfunction

    task automatic apply();
        for (int w = 0; w < NWIN; w++) begin
            win_base[w*AW +: AW]         = AW'(w_base[w]);
            win_size[w*SIZE_W +: SIZE_W] = SIZE_W'(w_size[w]);
            win_en[w]                    = 1'(w_en[w]);
            win_cfg[w*CFG_W +: CFG_W]    = pack(w);
        end
        dflt_cfg = pack(4);
    endtask

    // One request, driven and compared cycle by cycle against a queue
    // of expected pin states built from the requirements.
    task automatic run_tx(string tag, int addr, bit we, bit byt, bit [15:0] wd,
                          bit [15:0] d0, bit [15:0] d1, int extra);
        cyc_t q[$];
        cyc_t e;
        int sel = 4, beats, nseg, n;
        bit [15:0] rexp = 0;
        for (int w = 3; w >= 0; w--)
            if (w_en[w] != 0 && (((addr ^ w_base[w]) & 32'hFFFFFF) >> w_size[w]) == 0) sel = w;
        cs_hold_m = (sel < 4 && c_csm[sel] == 0) ? 4'(1 << sel) : 4'h0;
        case (seg_sel) 2'b00: nseg = 4; 2'b01: nseg = 0; 2'b10: nseg = 7; default: nseg = 2; endcase
        beats = (c_b16[sel] == 0 && !byt) ? 2 : 1;
        for (int b = 0; b < beats; b++) begin
            int a = addr + b;
            bit [7:0] bv = (beats == 2 && b == 1) ? wd[15:8] : wd[7:0];
            bit [15:0] lanes = (c_b16[sel] == 0) ? {8'h00, bv} : (byt ? {bv, bv} : wd);
            bit wl = we && (c_b16[sel] == 0 || !byt || a[0] == 0);
            bit wh = we && c_b16[sel] != 0 && (!byt || a[0] == 1);
            bit [15:0] dinb = (b == 0) ? d0 : d1;
            e = '{default: 0};
            e.addr = (c_mux[sel] != 0) ? 16'h0 : a[15:0];
            e.seg  = 7'((a >> 16) & ((1 << nseg) - 1));
            e.cs   = cs_hold_m;
            e.din  = 16'hDEAD;
            for (int k = 0; k < (c_along[sel] != 0 ? 2 : 1); k++) begin
                cyc_t x = e; x.ale = 1; x.doe = c_mux[sel] != 0; x.dout = x.doe ? a[15:0] : 0; q.push_back(x);
            end
            if (c_along[sel] != 0) begin
                cyc_t x = e; x.doe = c_mux[sel] != 0; x.dout = x.doe ? a[15:0] : 0; q.push_back(x);
            end
            if (c_dly[sel] != 0) q.push_back(e);
            n = c_wait[sel] + 1 + (c_rdy[sel] != 0 ? extra : 0);
            for (int j = 0; j < n; j++) begin
                cyc_t x = e;
                x.rd = !we; x.wrl = wl; x.wrh = wh; x.doe = we; x.dout = we ? lanes : 0;
                x.rdy = (c_rdy[sel] != 0) && (j < c_wait[sel] || j == n - 1);
                if (j == n - 1) x.din = dinb;
                if (sel < 4) x.cs = cs_hold_m | ((c_csm[sel] & 1) != 0 && x.rd ? 4'(1 << sel) : 4'h0)
                                              | ((c_csm[sel] & 2) != 0 && (wl || wh) ? 4'(1 << sel) : 4'h0);
                q.push_back(x);
            end
            begin
                cyc_t x = e;
                x.wrl = wl && c_early[sel] == 0; x.wrh = wh && c_early[sel] == 0;
                x.doe = we; x.dout = we ? lanes : 0;
                if (sel < 4 && (c_csm[sel] & 2) != 0 && (x.wrl || x.wrh)) x.cs = cs_hold_m | 4'(1 << sel);
                q.push_back(x);
            end
            if (c_trin[sel] == 0) begin
                cyc_t x = '{default: 0}; x.cs = cs_hold_m; q.push_back(x);
            end
            if (!we) begin
                if (c_b16[sel] != 0 && !byt) rexp = dinb;
                else if (c_b16[sel] != 0)    rexp = {8'h00, a[0] ? dinb[15:8] : dinb[7:0]};
                else if (byt)                rexp = {8'h00, dinb[7:0]};
                else if (b == 1)             rexp[15:8] = dinb[7:0];
                else                         rexp[7:0] = dinb[7:0];
            end
        end
        // Idle cycle before acceptance (R14 ready, R12 held chip select).
        chk("R14", {tag, " ready when idle"}, int'(req_ready), 1);
        chk("R3", {tag, " idle ale"}, int'(bus_ale), 0);
        req_addr = AW'(addr); req_we = we; req_byte = byt; req_wdata = wd; req_valid = 1;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        foreach (q[i]) begin
            bus_rdy = q[i].rdy; bus_din = q[i].din;
            chk("R3", tag, int'(bus_ale), int'(q[i].ale));
            chk("R5", tag, int'(bus_rd), int'(q[i].rd));
            chk("R8", tag, int'(bus_wrl), int'(q[i].wrl));
            chk("R9", tag, int'(bus_wrh), int'(q[i].wrh));
            chk("R2", tag, int'(bus_doe), int'(q[i].doe));
            chk("R2", {tag, " dout"}, int'(bus_dout), int'(q[i].dout));
            chk("R2", {tag, " addr"}, int'(bus_addr), int'(q[i].addr));
            chk("R11", tag, int'(bus_seg), int'(q[i].seg));
            chk("R12", tag, int'(bus_cs), int'(q[i].cs));
            chk("R14", {tag, " busy"}, int'(rsp_done), 0);
            @(negedge clk);
        end
        bus_rdy = 0; bus_din = 0;
        chk("R14", {tag, " done"}, int'(rsp_done), 1);
        if (!we) chk("R14", {tag, " rdata"}, int'(rsp_rdata), int'(rexp));
        chk("R12", {tag, " cs after"}, int'(bus_cs), int'(cs_hold_m));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        w_base = '{32'h100000, 32'h200000, 32'h200000, 32'h300000};
        w_size = '{16, 12, 20, 16};
        w_en   = '{1, 1, 1, 0};
        set_cfg(0, 0, 0, 1, 0, 0, 0, 1, 1, 0);
        set_cfg(1, 2, 1, 0, 0, 1, 1, 0, 1, 3);
        set_cfg(2, 1, 0, 1, 1, 0, 0, 1, 0, 2);
        set_cfg(3, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        set_cfg(4, 1, 0, 1, 0, 0, 0, 0, 1, 0);
        apply();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R13: reset state
        chk("R13", "reset ready", int'(req_ready), 1);
        chk("R13", "reset done", int'(rsp_done), 0);
        chk("R13", "reset strobes", int'({bus_ale, bus_rd, bus_wrl, bus_wrh, bus_doe}), 0);
        chk("R13", "reset cs", int'(bus_cs), 0);
        chk("R13", "reset addr", int'(bus_addr), 0);
        run_tx("R1 R2 mux word read", 32'h101234, 0, 0, 16'h0, 16'hA55A, 0, 0);
        run_tx("R8 R12 normal word write", 32'h101236, 1, 0, 16'h1357, 0, 0, 0);
        run_tx("R9 odd byte write", 32'h101237, 1, 1, 16'h00C3, 0, 0, 0);
        run_tx("R14 odd byte read", 32'h101239, 0, 1, 16'h0, 16'hBE00, 0, 0);
        run_tx("R3 R4 R6 R7 ready read", 32'h200100, 0, 0, 16'h0, 16'h4242, 0, 2);
        run_tx("R5 R6 R9 even byte write", 32'h200102, 1, 1, 16'h0077, 0, 0, 0);
        run_tx("R1 R8 R10 early split write", 32'h205000, 1, 0, 16'hBEEF, 0, 0, 0);
        run_tx("R10 R14 split read", 32'h205010, 0, 0, 16'h0, 16'h3311, 16'h4422, 0);
        run_tx("R1 disabled window default", 32'h300000, 0, 0, 16'h0, 16'h7777, 0, 0);
        seg_sel = 2'b00; run_tx("R11 four lines", 32'h7F1234, 0, 0, 16'h0, 16'h0101, 0, 0);
        seg_sel = 2'b10; run_tx("R11 seven lines", 32'h7F1234, 0, 0, 16'h0, 16'h0202, 0, 0);
        seg_sel = 2'b11; run_tx("R11 two lines", 32'h7F1234, 1, 0, 16'h5AA5, 0, 0, 0);
        seg_sel = 2'b01;
        // R6: ready with no extra, ready ignored when disabled
        run_tx("R6 ready no extra", 32'h200104, 0, 0, 16'h0, 16'h1234, 0, 0);
        w_en[3] = 1; apply();
        run_tx("R12 read chip select", 32'h300005, 0, 1, 16'h0, 16'h0099, 0, 0);
        run_tx("R12 read cs on write", 32'h300006, 1, 0, 16'hCAFE, 0, 0, 0);
        // R1: overlap resolves to lower index; R7 recovery on w1 write
        run_tx("R1 R7 priority write", 32'h200FFE, 1, 0, 16'h8001, 0, 0, 1);
        summary();
    end
endmodule